// File: doc/BRIEF.md
# Decimating ADC Sample Stream Framer

This block accepts 12-bit unsigned converter codes, each marked by a one-cycle valid strobe, and runs them through a fourth-order cascaded integrator-comb decimator with a rate change of four. At a 50 kS/s input rate this gives a 12.5 kS/s stream of 16-bit signed words. The filter gain is 256, and a 20-bit wraparound datapath keeps full precision. The output word takes bits [19:4] of the comb result, which is the scaled value divided by sixteen.

Each decimated word goes into a three-byte packet. The packet opens with a marker byte that carries a caller-supplied 4-bit status and the sticky overflow state, then holds the high and low sample bytes. An 8N1 serial transmitter sends the packet on a single line. A packet is 30 bit times long, which fits inside one output period at 500 kbit/s. If a new word arrives while a packet is still on the line, that word is discarded and a sticky overflow output is set.

Top module: `adc_decim_framer`

## Requirements
- R1: While reset is held and after it is released, the serial line is idle high and the overflow output is 0. Reset clears the overflow flag.
- R2: Input code 2048 means zero: the block subtracts 2048. A constant code 2048+d gives the word d*16 once the filter history holds only that input.
- R3: Output word k equals bits [19:4] of the sum of h[j]*x[4k+3-j] for j=0..12. Here x is the offset-corrected input, inputs before reset count as zero, and h = 1,4,10,20,31,40,44,40,31,20,10,4,1 (four boxcars of length 4 convolved). A single impulse therefore affects 13 consecutive input positions.
- R4: Exactly one word is formed for every fourth accepted sample since reset (the 4th, 8th, ...), and no word is formed at any other time.
- R5: A packet is sent as the marker byte, then the sample's high byte, then its low byte, each immediately after the previous one.
- R6: The marker byte has bit 7 = 1, bit 6 = overflow flag value when the word was formed, bits 5:4 = 2'b10, and bits 3:0 = the status input sampled with the fourth sample of the group.
- R7: Each byte is sent as a low start bit, 8 data bits LSB first and a high stop bit, each bit lasting CLKS_PER_BIT clocks. The line is high whenever no packet is in progress.
- R8: A word formed while a packet is still being sent produces no bytes and sets the overflow output. The overflow output stays high until reset, and the filter state still advances with the discarded samples.
- R9: Full-scale input does not corrupt the result: code 0 settles to word 0x8000 and code 4095 settles to word 0x7FF0.
- R10: Sample and status inputs are ignored in cycles where the valid strobe is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| i_clk | input | 1 | Clock |
| i_rst | input | 1 | Synchronous active-high reset |
| i_valid | input | 1 | One-cycle strobe marking a new converter code |
| i_sample | input | IN_W (12) | Unsigned converter code, mid-scale 2048 |
| i_status | input | 4 | Status nibble placed in the marker byte |
| o_tx | output | 1 | Serial output line, idle high |
| o_overflow | output | 1 | Sticky flag: a word was discarded |

## Verification
The bench aims at the filter's start-up transient, at full-scale codes where the 20-bit accumulators wrap, and at the 13-tap impulse response. A design with wrong integrator widths, a missing offset correction or a wrong decimation phase would produce words that drift, are offset, or come from a sample group shifted by one. A burst of closely spaced samples forces a word to collide with a packet in flight. A framer that interrupted the current packet, queued the late word or forgot the drop would garble bytes, add a packet or leave the flag low. Garbage on the data and status pins between strobes, and a final reset, show whether idle inputs or the sticky flag leak through.

// File: rtl/adcfr_pkg.sv
package adcfr_pkg;

    localparam int BYTE_W          = 8;
    localparam int STAT_W          = 4;
    localparam int UART_FRAME_BITS = BYTE_W + 2;

    typedef enum logic [1:0] {
        FR_IDLE = 2'd0,
        FR_SEND = 2'd1,
        FR_WAIT = 2'd2
    } fr_state_e;

    typedef struct packed {
        logic              ovf;
        logic [STAT_W-1:0] status;
    } side_info_t;

    // marker byte: top bit set, then overflow, fixed pattern, status
    function automatic logic [BYTE_W-1:0] make_sync(input side_info_t si);
        return {1'b1, si.ovf, 2'b10, si.status};
    endfunction

    // register width needed for N stages of rate-R growth
    function automatic int acc_width(input int in_w, input int order, input int decim);
        return in_w + order * $clog2(decim);
    endfunction

endpackage

// File: rtl/adcfr_integ.sv
module adcfr_integ #(
    parameter int IN_W  = 12,
    parameter int ORDER = 4,
    parameter int ACC_W = 20
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_vld,
    input  logic [IN_W-1:0]  in_code,
    output logic [ACC_W-1:0] acc_nxt
);

    logic [IN_W-1:0]  smp_s;
    logic [ACC_W-1:0] ext;

    // flip the top bit: unsigned mid-scale code becomes two's complement
    assign smp_s = {~in_code[IN_W-1], in_code[IN_W-2:0]};
    assign ext   = {{(ACC_W-IN_W){smp_s[IN_W-1]}}, smp_s};

    for (genvar g = 0; g < ORDER; g++) begin : g_stg
        logic [ACC_W-1:0] st_q;
        logic [ACC_W-1:0] st_d;
        logic [ACC_W-1:0] feed;

        if (g == 0) begin : g_head
            assign feed = ext;
        end else begin : g_tail
            assign feed = g_stg[g-1].st_d;
        end

        assign st_d = st_q + feed;

        always_ff @(posedge clk) begin
            if (rst) begin
                st_q <= '0;
            end else if (in_vld) begin
                st_q <= st_d;
            end
        end
    end

    // updated last stage, includes the sample presented this cycle
    assign acc_nxt = g_stg[ORDER-1].st_d;

endmodule

// File: rtl/adcfr_comb.sv
module adcfr_comb #(
    parameter int ACC_W = 20,
    parameter int OUT_W = 16,
    parameter int ORDER = 4,
    parameter int DECIM = 4,
    parameter int TAG_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_vld,
    input  logic [ACC_W-1:0] acc_in,
    input  logic [TAG_W-1:0] tag_in,
    output logic             word_vld,
    output logic [OUT_W-1:0] word,
    output logic [TAG_W-1:0] tag_out
);

    localparam int PH_W  = (DECIM > 1) ? $clog2(DECIM) : 1;
    localparam int SHIFT = ACC_W - OUT_W;

    logic [PH_W-1:0] phase_q;
    logic            dump;

    assign dump = in_vld && (phase_q == PH_W'(DECIM-1));

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= '0;
        end else if (in_vld) begin
            phase_q <= dump ? '0 : phase_q + PH_W'(1);
        end
    end

    for (genvar g = 0; g < ORDER; g++) begin : g_stg
        logic [ACC_W-1:0] dly_q;
        logic [ACC_W-1:0] feed;
        logic [ACC_W-1:0] diff;

        if (g == 0) begin : g_head
            assign feed = acc_in;
        end else begin : g_tail
            assign feed = g_stg[g-1].diff;
        end

        assign diff = feed - dly_q;

        always_ff @(posedge clk) begin
            if (rst) begin
                dly_q <= '0;
            end else if (dump) begin
                dly_q <= feed;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            word_vld <= 1'b0;
            word     <= '0;
            tag_out  <= '0;
        end else begin
            word_vld <= dump;
            if (dump) begin
                word    <= OUT_W'(g_stg[ORDER-1].diff >> SHIFT);
                tag_out <= tag_in;
            end
        end
    end

endmodule

// File: rtl/adcfr_framer.sv
module adcfr_framer
    import adcfr_pkg::*;
#(
    parameter int OUT_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              word_vld,
    input  logic [OUT_W-1:0]  word,
    input  logic [STAT_W-1:0] status,
    input  logic              tx_ready,
    output logic              tx_start,
    output logic [BYTE_W-1:0] tx_byte,
    output logic              busy,
    output logic              overflow
);

    localparam int NBYTES  = 1 + OUT_W / BYTE_W;
    localparam int FRAME_W = NBYTES * BYTE_W;
    localparam int CNT_W   = $clog2(NBYTES + 1);

    fr_state_e          st_q;
    logic [FRAME_W-1:0] fr_q;
    logic [CNT_W-1:0]   left_q;
    logic               ovf_q;
    side_info_t         si;

    assign si.ovf    = ovf_q;
    assign si.status = status;

    assign busy     = (st_q != FR_IDLE);
    assign overflow = ovf_q;
    assign tx_start = (st_q == FR_SEND) && tx_ready;
    assign tx_byte  = fr_q[FRAME_W-1 -: BYTE_W];

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= FR_IDLE;
            fr_q   <= '0;
            left_q <= '0;
            ovf_q  <= 1'b0;
        end else begin
            case (st_q)
                FR_IDLE: begin
                    if (word_vld) begin
                        fr_q   <= {make_sync(si), word};
                        left_q <= CNT_W'(NBYTES);
                        st_q   <= FR_SEND;
                    end
                end
                FR_SEND: begin
                    if (tx_ready) begin
                        fr_q   <= fr_q << BYTE_W;
                        left_q <= left_q - CNT_W'(1);
                        if (left_q == CNT_W'(1)) begin
                            st_q <= FR_WAIT;
                        end
                    end
                end
                FR_WAIT: begin
                    if (tx_ready) begin
                        st_q <= FR_IDLE;
                    end
                end
                default: st_q <= FR_IDLE;
            endcase
            // a word arriving mid-packet is discarded
            if (word_vld && st_q != FR_IDLE) begin
                ovf_q <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/adcfr_uart.sv
module adcfr_uart
    import adcfr_pkg::*;
#(
    parameter int CLKS_PER_BIT = 200
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [BYTE_W-1:0] data,
    output logic              ready,
    output logic              tx
);

    localparam int CNT_W = (CLKS_PER_BIT > 1) ? $clog2(CLKS_PER_BIT) : 1;
    localparam int BIT_W = $clog2(UART_FRAME_BITS + 1);

    logic                       run_q;
    logic [UART_FRAME_BITS-1:0] sh_q;
    logic [CNT_W-1:0]           cnt_q;
    logic [BIT_W-1:0]           bit_q;

    assign ready = !run_q;
    assign tx    = run_q ? sh_q[0] : 1'b1;

    always_ff @(posedge clk) begin
        if (rst) begin
            run_q <= 1'b0;
            sh_q  <= '1;
            cnt_q <= '0;
            bit_q <= '0;
        end else if (!run_q) begin
            if (start) begin
                run_q <= 1'b1;
                sh_q  <= {1'b1, data, 1'b0};
                cnt_q <= '0;
                bit_q <= '0;
            end
        end else if (cnt_q == CNT_W'(CLKS_PER_BIT-1)) begin
            cnt_q <= '0;
            sh_q  <= {1'b1, sh_q[UART_FRAME_BITS-1:1]};
            if (bit_q == BIT_W'(UART_FRAME_BITS-1)) begin
                run_q <= 1'b0;
            end else begin
                bit_q <= bit_q + BIT_W'(1);
            end
        end else begin
            cnt_q <= cnt_q + CNT_W'(1);
        end
    end

endmodule

// File: rtl/adc_decim_framer.sv
module adc_decim_framer
    import adcfr_pkg::*;
#(
    parameter int IN_W         = 12,
    parameter int OUT_W        = 16,
    parameter int ORDER        = 4,
    parameter int DECIM        = 4,
    parameter int CLKS_PER_BIT = 200
) (
    input  logic              i_clk,
    input  logic              i_rst,
    input  logic              i_valid,
    input  logic [IN_W-1:0]   i_sample,
    input  logic [STAT_W-1:0] i_status,
    output logic              o_tx,
    output logic              o_overflow
);

    localparam int ACC_W = acc_width(IN_W, ORDER, DECIM);

    logic [ACC_W-1:0]  acc_nxt;
    logic              w_vld;
    logic [OUT_W-1:0]  w_word;
    logic [STAT_W-1:0] w_stat;
    logic              u_start;
    logic              u_ready;
    logic [BYTE_W-1:0] u_byte;
    logic              f_busy;

    adcfr_integ #(
        .IN_W  (IN_W),
        .ORDER (ORDER),
        .ACC_W (ACC_W)
    ) u_integ (
        .clk     (i_clk),
        .rst     (i_rst),
        .in_vld  (i_valid),
        .in_code (i_sample),
        .acc_nxt (acc_nxt)
    );

    adcfr_comb #(
        .ACC_W (ACC_W),
        .OUT_W (OUT_W),
        .ORDER (ORDER),
        .DECIM (DECIM),
        .TAG_W (STAT_W)
    ) u_comb (
        .clk      (i_clk),
        .rst      (i_rst),
        .in_vld   (i_valid),
        .acc_in   (acc_nxt),
        .tag_in   (i_status),
        .word_vld (w_vld),
        .word     (w_word),
        .tag_out  (w_stat)
    );

    adcfr_framer #(
        .OUT_W (OUT_W)
    ) u_framer (
        .clk      (i_clk),
        .rst      (i_rst),
        .word_vld (w_vld),
        .word     (w_word),
        .status   (w_stat),
        .tx_ready (u_ready),
        .tx_start (u_start),
        .tx_byte  (u_byte),
        .busy     (f_busy),
        .overflow (o_overflow)
    );

    adcfr_uart #(
        .CLKS_PER_BIT (CLKS_PER_BIT)
    ) u_uart (
        .clk   (i_clk),
        .rst   (i_rst),
        .start (u_start),
        .data  (u_byte),
        .ready (u_ready),
        .tx    (o_tx)
    );

endmodule

// File: rtl/adcfr_chk.sv
module adcfr_chk (
    input logic clk,
    input logic rst,
    input logic valid,
    input logic tx,
    input logic ovf,
    input logic word_vld,
    input logic busy
);

    // R8
    ovf_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        ovf |=> ovf);

    // R8
    drop_flag_chk: assert property (@(posedge clk) disable iff (rst)
        (word_vld && busy) |=> ovf);

    // R5
    frame_open_chk: assert property (@(posedge clk) disable iff (rst)
        (word_vld && !busy) |=> busy);

    // R7
    idle_line_chk: assert property (@(posedge clk) disable iff (rst)
        !busy |-> tx);

    // R4
    word_src_chk: assert property (@(posedge clk) disable iff (rst)
        word_vld |-> $past(valid));

    // R4
    word_spacing_chk: assert property (@(posedge clk) disable iff (rst)
        word_vld |=> !word_vld);

endmodule

bind adc_decim_framer adcfr_chk u_chk (
    .clk      (i_clk),
    .rst      (i_rst),
    .valid    (i_valid),
    .tx       (o_tx),
    .ovf      (o_overflow),
    .word_vld (w_vld),
    .busy     (f_busy)
);

// File: tb/tb_adc_decim_framer.sv
module tb_adc_decim_framer;

    localparam int CPB = 4;
    localparam int GAP = 40;
    localparam int NTAP = 13;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        vld = 1'b0;
    logic [11:0] code = 12'd0;
    logic [3:0]  stat = 4'd0;
    logic        tx;
    logic        ovf;

    always #5 clk = ~clk;

    adc_decim_framer #(.CLKS_PER_BIT(CPB)) dut (
        .i_clk      (clk),
        .i_rst      (rst),
        .i_valid    (vld),
        .i_sample   (code),
        .i_status   (stat),
        .o_tx       (tx),
        .o_overflow (ovf)
    );

    typedef struct {
        logic [7:0] b;
        string      tag;
    } exp_t;

    exp_t expq[$];
    int   hist[$];
    int   h[NTAP];
    int   total = 0;
    int   bad = 0;
    bit   finished = 0;
    bit   m_ovf = 0;
    int   last_wd = 0;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // coefficients: four boxcars of length four convolved (R3)
    task automatic build_taps();
        int len = 1;
        for (int i = 0; i < NTAP; i++) h[i] = 0;
        h[0] = 1;
        repeat (4) begin
            int tmp[NTAP];
            for (int i = 0; i < NTAP; i++) tmp[i] = 0;
            for (int i = 0; i < len; i++)
                for (int k = 0; k < 4; k++) tmp[i+k] += h[i];
            for (int i = 0; i < NTAP; i++) h[i] = tmp[i];
            len += 3;
        end
    endtask

    // driver: one strobe, then garbage on idle pins (R10)
    task automatic send(input int c, input logic [3:0] s, input int gap,
                        input bit drop, input string tag);
        int idx;
        int y;
        logic [15:0] wd;
        code = c[11:0];
        stat = s;
        vld  = 1'b1;
        hist.push_back(c - 2048);
        idx = hist.size() - 1;
        if ((idx % 4) == 3) begin
            y = 0;
            for (int j = 0; j < NTAP; j++)
                if (idx - j >= 0) y += h[j] * hist[idx-j];
            wd = 16'(y >>> 4);
            last_wd = int'($signed(wd));
            if (drop) begin
                m_ovf = 1'b1;
            end else begin
                expq.push_back('{{1'b1, m_ovf, 2'b10, s}, {tag, " R6 marker"}});
                expq.push_back('{wd[15:8], {tag, " R5 high byte"}});
                expq.push_back('{wd[7:0],  {tag, " R5 low byte"}});
            end
        end
        @(negedge clk);
        vld  = 1'b0;
        code = 12'($urandom);
        stat = 4'($urandom);
        repeat (gap - 1) @(negedge clk);
    endtask

    task automatic run_const(input int c, input int n, input string tag);
        for (int i = 0; i < n; i++) send(c, 4'(i + 3), GAP, 1'b0, tag);
    endtask

    // monitor: decode 8N1 bytes and compare against the queue
    initial begin
        forever begin
            @(negedge clk);
            if (!rst && tx === 1'b0) begin
                logic [7:0] rx;
                exp_t e;
                repeat (CPB/2 - 1) @(negedge clk);
                chk(tx == 1'b0, "R7 start bit", int'(tx), 0);
                for (int i = 0; i < 8; i++) begin
                    repeat (CPB) @(negedge clk);
                    rx[i] = tx;
                end
                repeat (CPB) @(negedge clk);
                chk(tx == 1'b1, "R7 stop bit", int'(tx), 1);
                if (expq.size() == 0) begin
                    chk(1'b0, "R8 unexpected byte", int'(rx), 0);
                end else begin
                    e = expq.pop_front();
                    chk(rx == e.b, e.tag, int'(rx), int'(e.b));
                end
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            total++;
            bad++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        build_taps();
        repeat (5) @(negedge clk);
        chk(tx == 1'b1, "R1 line idle in reset", int'(tx), 1);
        chk(ovf == 1'b0, "R1 overflow clear in reset", int'(ovf), 0);
        rst = 1'b0;
        repeat (3) @(negedge clk);
        chk(tx == 1'b1, "R1 line idle after reset", int'(tx), 1);
        chk(ovf == 1'b0, "R1 overflow clear after reset", int'(ovf), 0);

        // R2 positive and negative DC
        run_const(2048 + 100, 16, "R2 dc +100");
        chk(last_wd == 100 * 16, "R2 settled +100", last_wd, 1600);
        run_const(2048 - 300, 16, "R2 dc -300");
        chk(last_wd == -300 * 16, "R2 settled -300", last_wd, -4800);

        // R9 full scale both ends
        run_const(0, 16, "R9 full negative");
        chk(last_wd == -32768, "R9 settled low", last_wd, -32768);
        run_const(4095, 16, "R9 full positive");
        chk(last_wd == 32752, "R9 settled high", last_wd, 32752);

        // R3 impulse at the 4th slot of a group, 13-tap span
        run_const(2048, 16, "R3 flush");
        run_const(2048, 3, "R3 pre-impulse");
        send(4095, 4'hA, GAP, 1'b0, "R3 impulse");
        run_const(2048, 16, "R3 impulse tail");
        chk(last_wd == 0, "R3 response ended", last_wd, 0);

        // R3 varied pattern with garbage between strobes (R10)
        for (int i = 0; i < 24; i++)
            send(2048 + ((i * 173) % 1500) - 750, 4'(i), GAP, 1'b0, "R3 R10 varied");

        // R8 collision burst
        repeat (200) @(negedge clk);
        chk(ovf == 1'b0, "R8 flag low before burst", int'(ovf), 0);
        for (int i = 0; i < 8; i++)
            send(2048 + 50 * i, 4'(9 + i), 1, (i == 7), "R8 burst");
        repeat (3) @(negedge clk);
        chk(ovf == 1'b1, "R8 flag set by drop", int'(ovf), 1);
        run_const(2048 + 10, 8, "R8 after drop");
        repeat (200) @(negedge clk);
        chk(ovf == 1'b1, "R8 flag sticky", int'(ovf), 1);
        chk(expq.size() == 0, "R4 all words delivered", expq.size(), 0);

        rst = 1'b1;
        repeat (3) @(negedge clk);
        chk(ovf == 1'b0, "R1 reset clears overflow", int'(ovf), 0);
        chk(tx == 1'b1, "R1 line idle in second reset", int'(tx), 1);

        if (!finished) begin
            finished = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule